// File: doc/BRIEF.md
# Four-to-One Word Serializer

This block turns a stream of 4-bit words into a serial bit stream running at four times the word rate. It runs entirely from a fast bit clock. From that clock it generates a parallel clock at one quarter of the bit rate. Upstream logic launches words on that parallel clock and returns it together with the data. The block latches each word on the rising edge of the returned clock. That edge may trail the generated one by up to two bit periods.

A 2-bit phase counter drives both the generated parallel clock and the hand-off into the output shift register. The hand-off happens on one fixed count. That count is placed late enough that a word captured anywhere in the allowed lag window has settled before the shift register takes it. The word then leaves the block most significant bit first, one bit per bit-clock cycle. Consecutive words follow each other with no gap. At the nominal rate of 622.08 Mb/s the word rate is 155.52 MHz.

The reset input is active low. It clears the block asynchronously, and the block leaves reset only on a bit-clock edge.

Top module: `nibble_serializer`

## Requirements
- R1: `par_clk_out` has a period of exactly four bit-clock cycles. It is high for the two cycles that follow its rising edge and low for the next two.
- R2: The word on `par_data` is captured only on a rising edge of `par_clk_in`. Values that `par_data` holds at any other time have no effect on `ser_out`.
- R3: Each captured word appears on `ser_out` in the order bit 3, bit 2, bit 1, bit 0, and each bit lasts one bit-clock cycle.
- R4: Bit 3 of a word appears on `ser_out` from the third bit-clock edge after the edge that raises `par_clk_out`. That edge is the word's hand-off point. The word shown is the one captured on the latest `par_clk_in` rise before the hand-off point.
- R5: Words follow one another on `ser_out` with no idle bit. Bit 0 of one word is followed directly by bit 3 of the next, and a hand-off occurs every four bit-clock cycles.
- R6: While `rst_n` is low, `ser_out` and `par_clk_out` are low; assertion of `rst_n` takes effect without waiting for a clock edge. After release, `ser_out` stays low until the first hand-off point.
- R7: R3 and R4 hold with the same output timing for every lag of the `par_clk_in` rising edge behind the `par_clk_out` rising edge of 0, 1 or 2 bit-clock periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| par_clk_in | input | 1 | Returned parallel clock; its rising edge captures `par_data` |
| par_data | input | 4 | Parallel word, bit 3 sent first |
| par_clk_out | output | 1 | Generated parallel clock, bit clock divided by four |
| ser_out | output | 1 | Serial data |

## Verification
The bench goes after the edges of the lag window. It repeats the whole stream with the returned clock lagging by zero, one and two bit periods. A hand-off placed too early would pick up the previous word at the largest lag. A capture made on the wrong clock would shift every word by a whole word slot. Between captures the bench floods `par_data` with junk values, so a design that samples the data bus outside the rising edge of `par_clk_in` sends corrupted words. Directed all-ones, all-zeros and alternating words expose a reversed bit order or a dropped or repeated bit at word boundaries. The bench also checks that `ser_out` stays low up to the first hand-off point and falls at once when reset is asserted mid-stream.

// File: rtl/nser_pkg.sv
package nser_pkg;
  // Serialization ratio (bits per parallel word); must be a power of two.
  localparam int unsigned NSER_RATIO_DEF = 4;

  // Default hand-off count: late enough for a returned-clock lag of up to
  // two bit periods to have captured before the shift register loads.
  function automatic int unsigned nser_handoff_count(input int unsigned ratio);
    return ratio - 2;
  endfunction
endpackage

// File: rtl/nser_reset_sync.sv
module nser_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/nser_phase_gen.sv
module nser_phase_gen #(
  parameter int unsigned RATIO      = nser_pkg::NSER_RATIO_DEF,
  parameter int unsigned HANDOFF_AT = nser_pkg::nser_handoff_count(RATIO)
) (
  input  logic clk,
  input  logic srst_n,
  output logic pclk_o,
  output logic handoff_o
);
  localparam int unsigned CW   = $clog2(RATIO);
  localparam int unsigned HALF = RATIO / 2;
  localparam logic [CW-1:0] LAST_CNT = CW'(RATIO - 1);
  localparam logic [CW-1:0] HO_CNT   = CW'(HANDOFF_AT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pclk_q, pclk_d;

  always_comb begin
    cnt_d  = (cnt_q == LAST_CNT) ? '0 : cnt_q + 1'b1;
    pclk_d = (32'(cnt_d) < HALF);
  end

  // Reset parks the counter on its last count so that the first edge
  // after release raises the parallel clock.
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q  <= LAST_CNT;
      pclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pclk_q <= pclk_d;
    end
  end

  assign pclk_o    = pclk_q;
  assign handoff_o = (cnt_q == HO_CNT);

  a_r1_high_two: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(pclk_q) |=> pclk_q);
  a_r1_low_two: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(pclk_q) |=> !pclk_q);
  a_r4_handoff_late: assert property (@(posedge clk) disable iff (!srst_n)
    handoff_o |-> (!pclk_q && $past(pclk_q, 2)));
endmodule

// File: rtl/nser_word_capture.sv
module nser_word_capture #(
  parameter int unsigned RATIO = nser_pkg::NSER_RATIO_DEF
) (
  input  logic             pclk_in,
  input  logic             srst_n,
  input  logic [RATIO-1:0] word_i,
  output logic [RATIO-1:0] word_o
);
  logic [RATIO-1:0] word_q;

  always_ff @(posedge pclk_in or negedge srst_n) begin
    if (!srst_n) word_q <= '0;
    else         word_q <= word_i;
  end

  assign word_o = word_q;
endmodule

// File: rtl/nser_shifter.sv
module nser_shifter #(
  parameter int unsigned RATIO = nser_pkg::NSER_RATIO_DEF
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             load_i,
  input  logic [RATIO-1:0] word_i,
  output logic             ser_o
);
  logic [RATIO-1:0] sh_q, sh_d;

  always_comb begin
    if (load_i) sh_d = word_i;
    else        sh_d = {sh_q[RATIO-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign ser_o = sh_q[RATIO-1];

  // R3: between loads the next lower bit moves up to the output.
  a_r3_msb_order: assert property (@(posedge clk) disable iff (!srst_n)
    !$past(load_i) |-> (sh_q[RATIO-1] == $past(sh_q[RATIO-2])));
endmodule

// File: rtl/nibble_serializer.sv
module nibble_serializer #(
  parameter int unsigned RATIO      = nser_pkg::NSER_RATIO_DEF,
  parameter int unsigned HANDOFF_AT = nser_pkg::nser_handoff_count(RATIO)
) (
  input  logic             bit_clk,
  input  logic             rst_n,
  input  logic             par_clk_in,
  input  logic [RATIO-1:0] par_data,
  output logic             par_clk_out,
  output logic             ser_out
);
  logic             srst_n;
  logic             handoff;
  logic [RATIO-1:0] cap_word;

  nser_reset_sync #(.STAGES(2)) u_rst (
    .clk   (bit_clk),
    .arst_n(rst_n),
    .srst_n(srst_n)
  );

  nser_phase_gen #(.RATIO(RATIO), .HANDOFF_AT(HANDOFF_AT)) u_phase (
    .clk      (bit_clk),
    .srst_n   (srst_n),
    .pclk_o   (par_clk_out),
    .handoff_o(handoff)
  );

  nser_word_capture #(.RATIO(RATIO)) u_cap (
    .pclk_in(par_clk_in),
    .srst_n (srst_n),
    .word_i (par_data),
    .word_o (cap_word)
  );

  nser_shifter #(.RATIO(RATIO)) u_shift (
    .clk   (bit_clk),
    .srst_n(srst_n),
    .load_i(handoff),
    .word_i(cap_word),
    .ser_o (ser_out)
  );

  // R5: one hand-off per word slot, back to back.
  a_r5_every_slot: assert property (@(posedge bit_clk) disable iff (!srst_n)
    handoff |-> ##4 handoff);
  // R4: the output shows the top bit of the word held at the hand-off.
  a_r4_top_bit_out: assert property (@(posedge bit_clk) disable iff (!srst_n)
    handoff |=> (ser_out == $past(cap_word[RATIO-1])));
endmodule

// File: tb/nibble_serializer_tb_top.sv
module nibble_serializer_tb_top;
  logic       bit_clk = 1'b0;
  logic       rst_n;
  logic       par_clk_in;
  logic [3:0] par_data;
  logic       par_clk_out;
  logic       ser_out;

  int unsigned errs = 0;
  int unsigned checks = 0;
  int          skew = 0;
  logic [1:0]  dly_q;
  bit          run = 0;
  bit          done = 0;
  logic [3:0]  last_cap = '0;
  logic [3:0]  loaded = '0;
  bit          have = 0;
  bit          seen_rise = 0;
  bit          prev_pclk = 0;
  int          ph = 0;

  always #2 bit_clk = ~bit_clk;

  nibble_serializer dut_i (
    .bit_clk    (bit_clk),
    .rst_n      (rst_n),
    .par_clk_in (par_clk_in),
    .par_data   (par_data),
    .par_clk_out(par_clk_out),
    .ser_out    (ser_out)
  );

  // Returned parallel clock: the generated one delayed by whole bit periods.
  always @(posedge bit_clk) dly_q <= {dly_q[0], par_clk_out};
  assign par_clk_in = (skew == 0) ? par_clk_out : (skew == 1) ? dly_q[0] : dly_q[1];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] word_at(input int i);
    case (i)
      0: return 4'hF;
      1: return 4'h0;
      2: return 4'hA;
      3: return 4'h5;
      4: return 4'h8;
      5: return 4'h1;
      default: return 4'($urandom);
    endcase
  endfunction

  function automatic logic exp_bit(input logic [3:0] w, input int p);
    return (p == 3) ? w[3] : w[2 - p];
  endfunction

  // Bench's own record of what each rising edge of the returned clock took.
  always @(posedge par_clk_in) if (run) last_cap = par_data;

  always @(negedge bit_clk) begin
    if (run) begin
      if (par_clk_out && !prev_pclk) begin
        if (seen_rise) chk(ph == 3, "R1 period", ph + 1, 4);
        ph = 0;
        seen_rise = 1;
      end else if (seen_rise) begin
        ph = (ph + 1) % 4;
      end
      prev_pclk = par_clk_out;
      if (seen_rise) begin
        chk(par_clk_out == (ph < 2), "R1 duty", int'(par_clk_out), int'(ph < 2));
        if (ph == 3) begin
          loaded = last_cap;
          have = 1;
        end
        if (have)
          chk(ser_out == exp_bit(loaded, ph), "R2/R3/R4/R5/R7 serial bit",
              int'(ser_out), int'(exp_bit(loaded, ph)));
        else
          chk(ser_out == 1'b0, "R6 low before first hand-off", int'(ser_out), 0);
      end else begin
        chk(ser_out == 1'b0, "R6 low before first hand-off", int'(ser_out), 0);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    par_data = 4'h0;
    repeat (3) @(negedge bit_clk);
    chk(ser_out == 1'b0, "R6 ser_out in reset", int'(ser_out), 0);
    chk(par_clk_out == 1'b0, "R6 par_clk_out in reset", int'(par_clk_out), 0);
    for (int s = 0; s < 3; s++) begin
      rst_n = 1'b0;
      skew = s;
      repeat (4) @(negedge bit_clk);
      chk(ser_out == 1'b0, "R6 ser_out in reset", int'(ser_out), 0);
      par_data = word_at(0);
      last_cap = '0;
      have = 0;
      seen_rise = 0;
      prev_pclk = 0;
      ph = 0;
      run = 1;
      rst_n = 1'b1;
      // R7: the same stream at every lag; junk between captures checks R2.
      for (int i = 0; i < 48; i++) begin
        @(posedge par_clk_in);
        @(negedge bit_clk) par_data = 4'($urandom);
        @(negedge par_clk_in);
        @(negedge bit_clk) par_data = word_at(i + 1);
      end
      repeat (6) @(negedge bit_clk);
      run = 0;
      // R6: asynchronous assertion mid-stream.
      par_data = 4'hF;
      @(posedge par_clk_in);
      @(negedge bit_clk);
      @(negedge bit_clk);
      @(negedge bit_clk);
      @(negedge bit_clk);
      #0.5 rst_n = 1'b0;
      #0.5;
      chk(ser_out == 1'b0, "R6 async clear ser_out", int'(ser_out), 0);
      chk(par_clk_out == 1'b0, "R6 async clear par_clk_out", int'(par_clk_out), 0);
    end
    finish_run();
  end
endmodule